// File: doc/BRIEF.md
# Weight-Stationary Streaming Matrix Unit

This block multiplies a tall left matrix A of n rows and S columns by a square S×S weight matrix B, producing C = A·B with n rows of S words. One descriptor starts a command. It carries the base addresses of A, B and C, the row count n, and a mode bit. The unit fetches all of B over its single word-wide memory port and holds it in local registers. It then reads A one row at a time and pushes each row through an S-stage systolic accumulation chain. Each finished C row is written back before the next A row is fetched.

The memory port belongs to the unit for the whole time it is busy. The memory answers a read in the cycle after the request. All three matrices are stored row-major with S words per row: B word (k, j) sits at b_base + k·S + j, A word (i, k) at a_base + i·S + k, and C word (i, j) at c_base + i·S + j. Only the low DW/4 bits of an A or B word are operands. The accumulator has the full word width, so a sum of S products cannot wrap. In Boolean mode each C element is written as 1 when the sum is non-zero and 0 otherwise, which gives reachability-style products.

Top module: `wsmu_top`

## Requirements
- R1: Out of reset, and again after every command completes, cmd_ready_o is 1, busy_o is 0, done_o is 0 and mem_req_o is 0.
- R2: After a descriptor is accepted, all S·S words of B are read row-major from b_base before any A word is read.
- R3: A command with n ≥ S rows writes n·S C words, where C[i][j] = Σk A[i][k]·B[k][j] stored at c_base + i·S + j.
- R4: Only bits [DW/4-1:0] of each A and B word take part in the product. Upper bits are ignored, and the full-width DW result never wraps.
- R5: With cmd_bool_i = 1, each C word is written as 1 if the sum is non-zero and as 0 if it is zero.
- R6: The first C write happens in the cycle S·S + 2S + 3 after acceptance, where the cycle following the accepting edge is cycle 1.
- R7: busy_o stays high for S·S + n·(3S+2) + 1 cycles. done_o is high for exactly the last of them, which immediately follows the last C write.
- R8: While busy, cmd_ready_o stays 0. A descriptor held valid during that time is accepted once the unit is idle, and it runs in full.
- R9: Each command writes only inside the C region [c_base, c_base + n·S).
- R10: B is read exactly S·S times per command, whatever n is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Descriptor valid |
| cmd_ready_o | output | 1 | Descriptor accepted when high with valid |
| cmd_a_addr_i | input | AW | Base address of A |
| cmd_b_addr_i | input | AW | Base address of B |
| cmd_c_addr_i | input | AW | Base address of C |
| cmd_rows_i | input | RW | Row count n of A, at least S |
| cmd_bool_i | input | 1 | Boolean clamp mode |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read request |

## Verification
The assertions assume that every accepted descriptor has a row count of at least S. They also assume the memory returns read data exactly one cycle after the request. The stimulus keeps to both: n is swept from S upward, and the bench memory is registered with a single cycle of latency. The regions for A, B and C never overlap, so no write-back can disturb operands still to be read. Operand words carry random upper bits, which shows that only the low quarter of each word is used.

// File: rtl/wsmu_pkg.sv
package wsmu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD_B, ST_LOAD_A, ST_FEED, ST_DRAIN, ST_STORE, ST_DONE
  } wsmu_state_e;

  typedef enum logic [1:0] {
    TAG_NONE, TAG_B, TAG_A
  } wsmu_tag_e;
endpackage

// File: rtl/wsmu_ctrl.sv
module wsmu_ctrl
  import wsmu_pkg::*;
#(
  parameter int S  = 4,
  parameter int AW = 16,
  parameter int RW = 16,
  localparam int IW = $clog2(S*S)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [AW-1:0] cmd_a_addr_i,
  input  logic [AW-1:0] cmd_b_addr_i,
  input  logic [AW-1:0] cmd_c_addr_i,
  input  logic [RW-1:0] cmd_rows_i,
  input  logic          cmd_bool_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          bool_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output wsmu_tag_e     rd_tag_o,
  output logic [IW-1:0] rd_idx_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          launch_o,
  input  logic          res_vld_i
);
  localparam logic [IW-1:0] LAST_B = IW'(S*S-1);
  localparam logic [IW-1:0] LAST_R = IW'(S-1);

  wsmu_state_e   state_q;
  logic [IW-1:0] cnt_q;
  logic [AW-1:0] b_base_q, a_ptr_q, c_ptr_q;
  logic [RW-1:0] rows_q, row_q;
  logic          bool_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      b_base_q <= '0;
      a_ptr_q  <= '0;
      c_ptr_q  <= '0;
      rows_q   <= '0;
      row_q    <= '0;
      bool_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          b_base_q <= cmd_b_addr_i;
          a_ptr_q  <= cmd_a_addr_i;
          c_ptr_q  <= cmd_c_addr_i;
          rows_q   <= cmd_rows_i;
          bool_q   <= cmd_bool_i;
          row_q    <= '0;
          cnt_q    <= '0;
          state_q  <= ST_LOAD_B;
        end
        ST_LOAD_B: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_B) begin
            cnt_q   <= '0;
            state_q <= ST_LOAD_A;
          end
        end
        ST_LOAD_A: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_R) begin
            cnt_q   <= '0;
            state_q <= ST_FEED;
          end
        end
        ST_FEED: state_q <= ST_DRAIN;
        ST_DRAIN: begin
          cnt_q <= IW'(1);
          if (res_vld_i) begin
            cnt_q   <= '0;
            state_q <= ST_STORE;
          end
        end
        ST_STORE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_R) begin
            cnt_q   <= '0;
            a_ptr_q <= a_ptr_q + AW'(S);
            c_ptr_q <= c_ptr_q + AW'(S);
            if (row_q == rows_q - 1'b1) state_q <= ST_DONE;
            else begin
              row_q   <= row_q + 1'b1;
              state_q <= ST_LOAD_A;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // read data returns one cycle after the request: tag it for the datapath
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_tag_o <= TAG_NONE;
      rd_idx_o <= '0;
    end else begin
      rd_tag_o <= (state_q == ST_LOAD_B) ? TAG_B :
                  (state_q == ST_LOAD_A) ? TAG_A : TAG_NONE;
      rd_idx_o <= cnt_q;
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    unique case (state_q)
      ST_LOAD_B: begin mem_req_o = 1'b1; mem_addr_o = b_base_q + AW'(cnt_q); end
      ST_LOAD_A: begin mem_req_o = 1'b1; mem_addr_o = a_ptr_q + AW'(cnt_q); end
      ST_STORE: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = c_ptr_q + AW'(cnt_q);
      end
      default: ;
    endcase
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign bool_o      = bool_q;
  assign wr_idx_o    = cnt_q;
  assign launch_o    = (state_q == ST_DRAIN) && (cnt_q == '0);

  assert_rows_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |-> (cmd_rows_i >= RW'(S)));

  assert_desc_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(rows_q) && $stable(b_base_q) && $stable(bool_q)));

  assert_done_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_we_o));
endmodule

// File: rtl/wsmu_weights.sv
module wsmu_weights #(
  parameter int S  = 4,
  parameter int OW = 4,
  localparam int IW = $clog2(S*S)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IW-1:0]             idx_i,
  input  logic [OW-1:0]             data_i,
  output logic [S*S-1:0][OW-1:0]    w_o
);
  logic [S*S-1:0][OW-1:0] w_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < S*S; i++)
        if (idx_i == IW'(i)) w_q[i] <= data_i;
    end
  end

  assign w_o = w_q;
endmodule

// File: rtl/wsmu_chain.sv
module wsmu_chain #(
  parameter int S  = 4,
  parameter int DW = 16,
  parameter int OW = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      launch_i,
  input  logic [S-1:0][OW-1:0]      row_i,
  input  logic [S*S-1:0][OW-1:0]    w_i,
  output logic                      vld_o,
  output logic [S-1:0][DW-1:0]      sum_o
);
  localparam int unsigned MAX_SUM = S * ((2**OW - 1) * (2**OW - 1));

  logic [S-1:0]                  vld_q, vld_in;
  logic [S-1:0][S-1:0][OW-1:0]   a_q, a_in;
  logic [S-1:0][S-1:0][DW-1:0]   ps_q, ps_in, ps_nxt;

  // stage k adds column-k operand times weight row k into every partial sum
  for (genvar k = 0; k < S; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign vld_in[k] = launch_i;
      assign a_in[k]   = row_i;
      assign ps_in[k]  = '0;
    end else begin : g_body
      assign vld_in[k] = vld_q[k-1];
      assign a_in[k]   = a_q[k-1];
      assign ps_in[k]  = ps_q[k-1];
    end
    for (genvar j = 0; j < S; j++) begin : g_col
      assign ps_nxt[k][j] = ps_in[k][j] + DW'(a_in[k][k]) * DW'(w_i[k*S+j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      a_q   <= '0;
      ps_q  <= '0;
    end else begin
      vld_q <= vld_in;
      a_q   <= a_in;
      ps_q  <= ps_nxt;
    end
  end

  logic a_tail_unused;
  assign a_tail_unused = ^a_q;

  assign vld_o = vld_q[S-1];
  assign sum_o = ps_q[S-1];

  for (genvar j = 0; j < S; j++) begin : g_chk
    assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> (32'(sum_o[j]) <= MAX_SUM));
  end
endmodule

// File: rtl/wsmu_top.sv
module wsmu_top
  import wsmu_pkg::*;
#(
  parameter int S  = 4,
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int RW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [AW-1:0] cmd_a_addr_i,
  input  logic [AW-1:0] cmd_b_addr_i,
  input  logic [AW-1:0] cmd_c_addr_i,
  input  logic [RW-1:0] cmd_rows_i,
  input  logic          cmd_bool_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int OW = DW / 4;
  localparam int IW = $clog2(S*S);

  wsmu_tag_e                rd_tag;
  logic [IW-1:0]            rd_idx, wr_idx;
  logic                     launch, chain_vld, bool_mode;
  logic [S*S-1:0][OW-1:0]   w;
  logic [S-1:0][OW-1:0]     row_q;
  logic [S-1:0][DW-1:0]     sum, res_q;

  wsmu_ctrl #(.S(S), .AW(AW), .RW(RW)) i_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o,
    .cmd_a_addr_i, .cmd_b_addr_i, .cmd_c_addr_i, .cmd_rows_i, .cmd_bool_i,
    .busy_o, .done_o, .bool_o(bool_mode),
    .mem_req_o, .mem_we_o, .mem_addr_o,
    .rd_tag_o(rd_tag), .rd_idx_o(rd_idx), .wr_idx_o(wr_idx),
    .launch_o(launch), .res_vld_i(chain_vld)
  );

  wsmu_weights #(.S(S), .OW(OW)) i_weights (
    .clk_i, .rst_ni,
    .we_i(rd_tag == TAG_B), .idx_i(rd_idx), .data_i(mem_rdata_i[OW-1:0]),
    .w_o(w)
  );

  wsmu_chain #(.S(S), .DW(DW), .OW(OW)) i_chain (
    .clk_i, .rst_ni, .launch_i(launch), .row_i(row_q), .w_i(w),
    .vld_o(chain_vld), .sum_o(sum)
  );

  logic rdata_hi_unused;
  assign rdata_hi_unused = ^mem_rdata_i[DW-1:OW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      res_q <= '0;
    end else begin
      if (rd_tag == TAG_A)
        for (int i = 0; i < S; i++)
          if (rd_idx == IW'(i)) row_q[i] <= mem_rdata_i[OW-1:0];
      if (chain_vld)
        for (int i = 0; i < S; i++)
          res_q[i] <= bool_mode ? DW'(sum[i] != '0) : sum[i];
    end
  end

  always_comb begin
    mem_wdata_o = '0;
    for (int i = 0; i < S; i++)
      if (wr_idx == IW'(i)) mem_wdata_o = res_q[i];
  end

  assert_store_after_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && wr_idx == '0) |-> $past(chain_vld));

  assert_bool_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && bool_mode) |-> (mem_wdata_o <= DW'(1)));

  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!mem_req_o && !chain_vld));
endmodule

// File: tb/test_wsmu_top.sv
`timescale 1ns/1ps
module test_wsmu_top;
  localparam int S  = 4;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int RW = 16;
  localparam int OW = DW / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_a = '0, cmd_b = '0, cmd_c = '0;
  logic [RW-1:0] cmd_rows = '0;
  logic          cmd_bool = 1'b0;
  logic          busy, done;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  wsmu_top #(.S(S), .DW(DW), .AW(AW), .RW(RW)) i_wsmu_top (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_a_addr_i(cmd_a), .cmd_b_addr_i(cmd_b), .cmd_c_addr_i(cmd_c),
    .cmd_rows_i(cmd_rows), .cmd_bool_i(cmd_bool),
    .busy_o(busy), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [DW-1:0] mem [0:1023];
  int checks = 0, fails = 0;
  int b_reads = 0, order_err = 0, bad_wr = 0;
  logic clr = 1'b0;
  int a_lo, a_hi, b_lo, b_hi, c_lo, c_hi;

  // single-cycle-latency memory model with access bookkeeping
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end
    if (clr) begin
      b_reads <= 0; order_err <= 0; bad_wr <= 0;
    end else if (mem_req) begin
      if (mem_we) begin
        if (int'(mem_addr) < c_lo || int'(mem_addr) >= c_hi) bad_wr <= bad_wr + 1;
      end else begin
        if (int'(mem_addr) >= b_lo && int'(mem_addr) < b_hi) b_reads <= b_reads + 1;
        if (int'(mem_addr) >= a_lo && int'(mem_addr) < a_hi && b_reads < S*S)
          order_err <= order_err + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill(input int a, input int b, input int n, input int pat);
    for (int i = 0; i < n*S + S*S; i++) begin
      logic [DW-1:0] v;
      v = DW'($urandom);
      case (pat)
        1: v[OW-1:0] = '1;
        2: if ($urandom % 4 != 0) v[OW-1:0] = '0;
        default: ;
      endcase
      if (i < S*S) mem[b + i] = v;
      else         mem[a + i - S*S] = v;
    end
  endtask

  task automatic start_cmd(input int a, input int b, input int c, input int n, input bit bm);
    a_lo = a; a_hi = a + n*S; b_lo = b; b_hi = b + S*S; c_lo = c; c_hi = c + n*S;
    cmd_a = AW'(a); cmd_b = AW'(b); cmd_c = AW'(c); cmd_rows = RW'(n); cmd_bool = bm;
    cmd_valid = 1'b1;
    clr = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    clr = 1'b0;
    cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input int a, input int b, input int c, input int n, input bit bm);
    int cyc = 1, first_wr = -1, last_wr = -1, done_cyc = -1;
    bit ready_bad = 0;
    forever begin
      if (mem_req && mem_we) begin
        if (first_wr < 0) first_wr = cyc;
        last_wr = cyc;
      end
      if (cmd_ready) ready_bad = 1;
      if (done) begin done_cyc = cyc; break; end
      if (cyc > 5000) break;
      @(negedge clk);
      cyc++;
    end
    chk(first_wr == S*S + 2*S + 3, "R6 first write cycle", first_wr, S*S + 2*S + 3);
    chk(done_cyc == S*S + n*(3*S+2) + 1, "R7 busy length", done_cyc, S*S + n*(3*S+2) + 1);
    chk(last_wr == done_cyc - 1, "R7 done follows last write", last_wr, done_cyc - 1);
    chk(!ready_bad, "R8 ready low while busy", int'(ready_bad), 0);
    @(negedge clk);
    chk(cmd_ready && !busy && !done && !mem_req, "R1 idle after command",
        int'({cmd_ready, busy, done, mem_req}), 8);
    chk(b_reads == S*S, "R10 B read count", b_reads, S*S);
    chk(order_err == 0, "R2 A read before B loaded", order_err, 0);
    chk(bad_wr == 0, "R9 write outside C", bad_wr, 0);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < S; j++) begin
        int e = 0;
        for (int k = 0; k < S; k++)
          e += int'(mem[a + i*S + k][OW-1:0]) * int'(mem[b + k*S + j][OW-1:0]);
        if (bm) e = (e != 0) ? 1 : 0;
        chk(int'(mem[c + i*S + j]) == e, bm ? "R5 R4 bool element" : "R3 R4 element",
            int'(mem[c + i*S + j]), e);
      end
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    @(negedge clk);
    chk(cmd_ready && !busy && !done && !mem_req, "R1 reset state",
        int'({cmd_ready, busy, done, mem_req}), 8);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !busy && !done && !mem_req, "R1 after reset",
        int'({cmd_ready, busy, done, mem_req}), 8);

    // sweep of row counts, modes and operand patterns
    for (int n = S; n <= S + 4; n++)
      for (int bm = 0; bm < 2; bm++)
        for (int pat = 0; pat < 3; pat++) begin
          fill(16'h100, 16'h040, n, pat);
          start_cmd(16'h100, 16'h040, 16'h200, n, bm[0]);
          run_cmd(16'h100, 16'h040, 16'h200, n, bm[0]);
        end

    // R8: second descriptor held valid while the first runs
    fill(16'h100, 16'h040, 5, 0);
    fill(16'h280, 16'h060, 9, 2);
    start_cmd(16'h100, 16'h040, 16'h200, 5, 1'b0);
    cmd_a = 16'h280; cmd_b = 16'h060; cmd_c = 16'h300; cmd_rows = RW'(9); cmd_bool = 1'b1;
    cmd_valid = 1'b1;
    run_cmd(16'h100, 16'h040, 16'h200, 5, 1'b0);
    start_cmd(16'h280, 16'h060, 16'h300, 9, 1'b1);
    run_cmd(16'h280, 16'h060, 16'h300, 9, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule